// File: doc/BRIEF.md
# Page-Boundary DMA Transfer Splitter

This block turns one DMA request into a series of page-sized memory accesses. A request gives a virtual start address, a byte count and a direction. The block cuts the request into chunks, and no chunk crosses a 4 KB page boundary. For each chunk it sends the virtual page number to an external translation unit. That unit returns a physical page together with a valid flag and a write-permission flag. The block then issues the chunk to a physical memory port as a byte address and a byte count.

The transfer aborts at the first chunk that faults, before any data of that chunk moves. When the transfer ends, a one-cycle completion pulse reports success or abort and the number of bytes moved. Data buffering and the page-table walk are outside the block. It handles only chunk sequencing, length arithmetic and abort handling.

Four interfaces cross the block's edge: the request, the translation request, the translation response and the memory port. The request, the translation request and the memory port use valid/ready. A payload is taken on a clock edge where valid and ready are both high. While valid is high and ready is low, the sender holds valid and its payload unchanged. The translation response is a single-cycle valid with no ready, because the block is always waiting for it while a lookup is outstanding. The completion signals are plain outputs.

Top module: `dma_page_splitter`

## Requirements
- R1: After reset, req_ready is 1 and done, xlt_req_valid and mem_valid are 0. req_ready is high only while no transfer is in progress, and it is low during every translation and memory phase.
- R2: Each chunk carries mem_bytes equal to the smaller of two values: the bytes still to move, and 4096 minus the low 12 address bits. A chunk is never empty and never crosses a 4 KB boundary.
- R3: Before each chunk's memory access, the block issues exactly one translation request. Its xlt_vpage is the chunk's virtual address bits [VA_W-1:12].
- R4: mem_addr equals {xlt_rsp_ppage, the chunk's virtual address bits [11:0]}. mem_write equals the req_write value captured with the request.
- R5: After each accepted memory chunk, the virtual address advances by the chunk length and the remaining count drops by the same amount. Chunks are issued in ascending address order (modulo 2^VA_W) until zero bytes remain.
- R6: A translation response with xlt_rsp_ok = 0 aborts the transfer. No further memory access or translation request follows. done pulses with done_ok = 0, and done_bytes holds the bytes of the chunks already completed.
- R7: On a write request (req_write = 1), a response with xlt_rsp_wr = 0 aborts the transfer in the same way as R6. On a read request, xlt_rsp_wr has no effect.
- R8: done is high for exactly one cycle. On success it comes in the cycle after the last chunk's memory handshake, with done_ok = 1 and done_bytes equal to req_len.
- R9: A request with req_len = 0 makes done pulse in the next cycle, with done_ok = 1 and done_bytes = 0, and no translation request is issued.
- R10: While xlt_req_valid or mem_valid is high and the matching ready is low, the valid stays high and its payload stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and accepting a request |
| req_addr | input | VA_W | Virtual start address |
| req_len | input | LEN_W | Byte count |
| req_write | input | 1 | 1 = write to memory, 0 = read |
| xlt_req_valid | output | 1 | Translation lookup requested |
| xlt_req_ready | input | 1 | Translation unit accepts the lookup |
| xlt_vpage | output | VA_W-12 | Virtual page number to translate |
| xlt_rsp_valid | input | 1 | Single-cycle translation result |
| xlt_rsp_ok | input | 1 | Entry is valid |
| xlt_rsp_wr | input | 1 | Entry permits writes |
| xlt_rsp_ppage | input | PA_W-12 | Physical page number |
| mem_valid | output | 1 | Memory chunk offered |
| mem_ready | input | 1 | Memory port accepts the chunk |
| mem_addr | output | PA_W | Physical byte address of the chunk |
| mem_bytes | output | 13 | Chunk byte count (1 to 4096) |
| mem_write | output | 1 | Chunk direction |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | 1 = all bytes moved, 0 = aborted |
| done_bytes | output | LEN_W | Bytes moved before completion |

## Verification
The sweep combines start offsets at the start, middle and last bytes of a page with lengths of zero, one byte, one short of a page, exactly a page, one over a page and several pages. These combinations separate the single-chunk case from the split case and expose off-by-one errors in the page room arithmetic. One base sits near the top of the address space so that page numbers wrap. Faults are placed on the first, middle and last chunk of a four-chunk transfer. Each position is tried with an invalid entry and with a missing write permission, in both directions, which separates an abort on a write from the ignored permission on a read. Stalls of varying length on the translation and memory handshakes show whether the payloads hold steady under back-pressure.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XLT,
    ST_WAIT,
    ST_MEM,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/dps_chunk_math.sv
module dps_chunk_math #(
  parameter int PAGE_SHIFT = 12,
  parameter int LEN_W      = 16
) (
  input  logic [PAGE_SHIFT-1:0] offset,
  input  logic [LEN_W-1:0]      remaining,
  output logic [PAGE_SHIFT:0]   chunk,
  output logic                  last
);
  localparam int CW = PAGE_SHIFT + 1;
  localparam int MW = (LEN_W > CW) ? LEN_W : CW;

  logic [MW-1:0] room_w;
  logic [MW-1:0] rem_w;

  always_comb begin
    room_w = (MW'(1) << PAGE_SHIFT) - MW'(offset);
    rem_w  = MW'(remaining);
    if (rem_w <= room_w) begin
      chunk = CW'(rem_w);
      last  = 1'b1;
    end else begin
      chunk = CW'(room_w);
      last  = 1'b0;
    end
  end
endmodule

// File: rtl/dps_perm_check.sv
module dps_perm_check (
  input  logic entry_ok,
  input  logic entry_wr,
  input  logic is_write,
  output logic fault
);
  logic no_entry;
  logic no_write;

  always_comb begin
    no_entry = !entry_ok;
    no_write = is_write && !entry_wr;
    fault    = no_entry || no_write;
  end
endmodule

// File: rtl/dps_seq.sv
module dps_seq
  import dps_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 36,
  parameter int LEN_W      = 16,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [VA_W-1:0]            req_addr,
  input  logic [LEN_W-1:0]           req_len,
  input  logic                       req_write,
  output logic                       xlt_req_valid,
  input  logic                       xlt_req_ready,
  output logic [VA_W-PAGE_SHIFT-1:0] xlt_vpage,
  input  logic                       xlt_rsp_valid,
  input  logic [PA_W-PAGE_SHIFT-1:0] xlt_rsp_ppage,
  input  logic                       fault,
  output logic                       mem_valid,
  input  logic                       mem_ready,
  output logic [PA_W-1:0]            mem_addr,
  output logic                       mem_write,
  output logic                       done,
  output logic                       done_ok,
  output logic [LEN_W-1:0]           done_bytes,
  output logic [PAGE_SHIFT-1:0]      cur_offset,
  output logic [LEN_W-1:0]           cur_remaining,
  input  logic [PAGE_SHIFT:0]        chunk,
  input  logic                       last
);
  localparam int PPW = PA_W - PAGE_SHIFT;

  seq_state_e          state;
  logic [VA_W-1:0]     cur_addr;
  logic [LEN_W-1:0]    rem_q;
  logic [LEN_W-1:0]    moved_q;
  logic                dir_q;
  logic                ok_q;
  logic [PPW-1:0]      ppage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      rem_q    <= '0;
      moved_q  <= '0;
      dir_q    <= 1'b0;
      ok_q     <= 1'b0;
      ppage_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_addr <= req_addr;
            rem_q    <= req_len;
            dir_q    <= req_write;
            moved_q  <= '0;
            if (req_len == '0) begin
              ok_q  <= 1'b1;
              state <= ST_DONE;
            end else begin
              state <= ST_XLT;
            end
          end
        end
        ST_XLT: begin
          if (xlt_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (xlt_rsp_valid) begin
            if (fault) begin
              ok_q  <= 1'b0;
              state <= ST_DONE;
            end else begin
              ppage_q <= xlt_rsp_ppage;
              state   <= ST_MEM;
            end
          end
        end
        ST_MEM: begin
          if (mem_ready) begin
            cur_addr <= cur_addr + VA_W'(chunk);
            rem_q    <= rem_q - LEN_W'(chunk);
            moved_q  <= moved_q + LEN_W'(chunk);
            if (last) begin
              ok_q  <= 1'b1;
              state <= ST_DONE;
            end else begin
              state <= ST_XLT;
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready     = (state == ST_IDLE);
    xlt_req_valid = (state == ST_XLT);
    xlt_vpage     = cur_addr[VA_W-1:PAGE_SHIFT];
    mem_valid     = (state == ST_MEM);
    mem_addr      = {ppage_q, cur_addr[PAGE_SHIFT-1:0]};
    mem_write     = dir_q;
    done          = (state == ST_DONE);
    done_ok       = ok_q;
    done_bytes    = moved_q;
    cur_offset    = cur_addr[PAGE_SHIFT-1:0];
    cur_remaining = rem_q;
  end
endmodule

// File: rtl/dma_page_splitter.sv
module dma_page_splitter #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 36,
  parameter int LEN_W      = 16,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [VA_W-1:0]            req_addr,
  input  logic [LEN_W-1:0]           req_len,
  input  logic                       req_write,
  output logic                       xlt_req_valid,
  input  logic                       xlt_req_ready,
  output logic [VA_W-PAGE_SHIFT-1:0] xlt_vpage,
  input  logic                       xlt_rsp_valid,
  input  logic                       xlt_rsp_ok,
  input  logic                       xlt_rsp_wr,
  input  logic [PA_W-PAGE_SHIFT-1:0] xlt_rsp_ppage,
  output logic                       mem_valid,
  input  logic                       mem_ready,
  output logic [PA_W-1:0]            mem_addr,
  output logic [PAGE_SHIFT:0]        mem_bytes,
  output logic                       mem_write,
  output logic                       done,
  output logic                       done_ok,
  output logic [LEN_W-1:0]           done_bytes
);
  logic [PAGE_SHIFT-1:0] cur_offset;
  logic [LEN_W-1:0]      cur_remaining;
  logic [PAGE_SHIFT:0]   chunk;
  logic                  last;
  logic                  fault;

  dps_chunk_math #(.PAGE_SHIFT(PAGE_SHIFT), .LEN_W(LEN_W)) u_math (
    .offset    (cur_offset),
    .remaining (cur_remaining),
    .chunk     (chunk),
    .last      (last)
  );

  dps_perm_check u_perm (
    .entry_ok (xlt_rsp_ok),
    .entry_wr (xlt_rsp_wr),
    .is_write (mem_write),
    .fault    (fault)
  );

  dps_seq #(.VA_W(VA_W), .PA_W(PA_W), .LEN_W(LEN_W), .PAGE_SHIFT(PAGE_SHIFT)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .req_len       (req_len),
    .req_write     (req_write),
    .xlt_req_valid (xlt_req_valid),
    .xlt_req_ready (xlt_req_ready),
    .xlt_vpage     (xlt_vpage),
    .xlt_rsp_valid (xlt_rsp_valid),
    .xlt_rsp_ppage (xlt_rsp_ppage),
    .fault         (fault),
    .mem_valid     (mem_valid),
    .mem_ready     (mem_ready),
    .mem_addr      (mem_addr),
    .mem_write     (mem_write),
    .done          (done),
    .done_ok       (done_ok),
    .done_bytes    (done_bytes),
    .cur_offset    (cur_offset),
    .cur_remaining (cur_remaining),
    .chunk         (chunk),
    .last          (last)
  );

  assign mem_bytes = chunk;
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 36,
  parameter int LEN_W      = 16,
  parameter int PAGE_SHIFT = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic [VA_W-1:0]            req_addr,
  input logic [LEN_W-1:0]           req_len,
  input logic                       req_write,
  input logic                       xlt_req_valid,
  input logic                       xlt_req_ready,
  input logic [VA_W-PAGE_SHIFT-1:0] xlt_vpage,
  input logic                       xlt_rsp_valid,
  input logic                       xlt_rsp_ok,
  input logic                       xlt_rsp_wr,
  input logic [PA_W-PAGE_SHIFT-1:0] xlt_rsp_ppage,
  input logic                       mem_valid,
  input logic                       mem_ready,
  input logic [PA_W-1:0]            mem_addr,
  input logic [PAGE_SHIFT:0]        mem_bytes,
  input logic                       mem_write,
  input logic                       done,
  input logic                       done_ok,
  input logic [LEN_W-1:0]           done_bytes
);
  localparam int EW = PAGE_SHIFT + 2;

  logic          pending;
  logic          translated;
  logic [EW-1:0] end_off;

  assign end_off = EW'(mem_addr[PAGE_SHIFT-1:0]) + EW'(mem_bytes);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending    <= 1'b0;
      translated <= 1'b0;
    end else begin
      if (xlt_req_valid && xlt_req_ready) pending <= 1'b1;
      else if (xlt_rsp_valid)             pending <= 1'b0;
      if (pending && xlt_rsp_valid)                  translated <= 1'b1;
      else if ((mem_valid && mem_ready) || done)     translated <= 1'b0;
    end
  end

  // R1
  idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(xlt_req_valid || mem_valid));

  // R2
  chunk_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_bytes != '0) && (end_off <= (EW'(1) << PAGE_SHIFT)));

  // R3
  xlt_before_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> translated);

  // R6
  abort_on_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && xlt_rsp_valid && !xlt_rsp_ok) |=> (done && !done_ok));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len == '0)) |=> (done && done_ok && (done_bytes == '0)));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_bytes)));

  // R10
  xlt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xlt_req_valid && !xlt_req_ready) |=> (xlt_req_valid && $stable(xlt_vpage)));
endmodule

bind dma_page_splitter dps_checker #(
  .VA_W(VA_W), .PA_W(PA_W), .LEN_W(LEN_W), .PAGE_SHIFT(PAGE_SHIFT)
) u_chk (.*);

// File: tb/dma_page_splitter_bench.sv
module dma_page_splitter_bench;
  localparam int VA_W = 32;
  localparam int PA_W = 36;
  localparam int LEN_W = 16;
  localparam int PS = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [VA_W-1:0]   req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              req_write = 1'b0;
  logic              xlt_req_valid;
  logic              xlt_req_ready = 1'b0;
  logic [VA_W-PS-1:0] xlt_vpage;
  logic              xlt_rsp_valid = 1'b0;
  logic              xlt_rsp_ok = 1'b0;
  logic              xlt_rsp_wr = 1'b0;
  logic [PA_W-PS-1:0] xlt_rsp_ppage = '0;
  logic              mem_valid;
  logic              mem_ready = 1'b0;
  logic [PA_W-1:0]   mem_addr;
  logic [PS:0]       mem_bytes;
  logic              mem_write;
  logic              done;
  logic              done_ok;
  logic [LEN_W-1:0]  done_bytes;

  int n_checks = 0;
  int n_fails = 0;

  always #5 clk = ~clk;

  dma_page_splitter u_dma_page_splitter (.*);

  function automatic logic [PA_W-PS-1:0] pmap(input logic [VA_W-PS-1:0] v);
    return {v ^ 20'h5A3C7, 4'h3};
  endfunction

  task automatic chk(input bit cond, input string rq, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!cond) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  // fkind: 0 = invalid entry, 1 = no write permission
  task automatic xfer(input logic [VA_W-1:0] a0, input int len, input bit wr,
                      input int fidx, input int fkind, input int stall);
    logic [VA_W-1:0] a;
    int rem, moved, idx, c, room, t;
    bit bad;
    chk(req_ready == 1'b1, "R1", "idle ready", req_ready, 1);
    req_valid = 1'b1; req_addr = a0; req_len = LEN_W'(len); req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    if (len == 0) begin
      chk(done && done_ok && done_bytes == 0, "R9", "zero-length done",
          {done, done_ok, done_bytes}, {2'b11, 16'h0});
      chk(!xlt_req_valid, "R9", "no lookup", xlt_req_valid, 0);
      @(negedge clk);
      return;
    end
    a = a0; rem = len; moved = 0; idx = 0;
    while (rem > 0) begin
      room = 4096 - int'(a[PS-1:0]);
      c = (rem < room) ? rem : room;
      t = 0;
      while (!xlt_req_valid && t < 40) begin @(negedge clk); t++; end
      chk(xlt_req_valid, "R3", "lookup issued", xlt_req_valid, 1);
      chk(!req_ready, "R1", "busy not ready", req_ready, 0);
      chk(xlt_vpage == a[VA_W-1:PS], "R3", "lookup page", xlt_vpage, a[VA_W-1:PS]);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(xlt_req_valid && xlt_vpage == a[VA_W-1:PS], "R10", "lookup held",
            xlt_vpage, a[VA_W-1:PS]);
      end
      xlt_req_ready = 1'b1;
      @(negedge clk);
      xlt_req_ready = 1'b0;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(!mem_valid && !xlt_req_valid, "R3", "wait for response",
            {mem_valid, xlt_req_valid}, 0);
      end
      bad = (idx == fidx) && ((fkind == 0) || wr);
      xlt_rsp_valid = 1'b1;
      xlt_rsp_ok = !((idx == fidx) && (fkind == 0));
      xlt_rsp_wr = !((idx == fidx) && (fkind == 1));
      xlt_rsp_ppage = pmap(a[VA_W-1:PS]);
      @(negedge clk);
      xlt_rsp_valid = 1'b0;
      if (bad) begin
        chk(done && !done_ok, fkind == 0 ? "R6" : "R7", "abort pulse",
            {done, done_ok}, 2'b10);
        chk(done_bytes == LEN_W'(moved), fkind == 0 ? "R6" : "R7", "abort bytes",
            done_bytes, moved);
        chk(!mem_valid, "R6", "no chunk after fault", mem_valid, 0);
        @(negedge clk);
        chk(!xlt_req_valid && !mem_valid && !done, "R6", "stopped",
            {xlt_req_valid, mem_valid, done}, 0);
        return;
      end
      chk(mem_valid, "R7", "chunk issued", mem_valid, 1);
      chk(mem_bytes == (PS+1)'(c), "R2", "chunk length", mem_bytes, c);
      chk(mem_addr == {pmap(a[VA_W-1:PS]), a[PS-1:0]}, "R4", "chunk address",
          mem_addr, {pmap(a[VA_W-1:PS]), a[PS-1:0]});
      chk(mem_write == wr, "R4", "chunk direction", mem_write, wr);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(mem_valid && mem_bytes == (PS+1)'(c), "R10", "chunk held", mem_bytes, c);
      end
      mem_ready = 1'b1;
      @(negedge clk);
      mem_ready = 1'b0;
      a = a + VA_W'(c); rem = rem - c; moved = moved + c; idx++;
      if (rem > 0) chk(!done, "R5", "no early done", done, 0);
    end
    chk(done && done_ok, "R8", "success pulse", {done, done_ok}, 2'b11);
    chk(done_bytes == LEN_W'(len), "R8", "total bytes", done_bytes, len);
    @(negedge clk);
    chk(!done, "R8", "single-cycle done", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int offs[5];
    int lens[8];
    logic [VA_W-1:0] bases[3];
    offs = '{0, 1, 'h800, 'hffc, 'hfff};
    lens = '{0, 1, 4, 'hfff, 'h1000, 'h1001, 'h2000, 9000};
    bases = '{32'h0001_0000, 32'h7ff3_0000, 32'hffff_e000};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready && !done && !xlt_req_valid && !mem_valid, "R1", "reset outputs",
        {req_ready, done, xlt_req_valid, mem_valid}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R4 R5 R8 R9 R10: sweep without faults
    for (int b = 0; b < 3; b++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 8; j++)
          for (int d = 0; d < 2; d++)
            xfer(bases[b] + VA_W'(offs[i]), lens[j], d[0], -1, 0, (i + j + b) % 3);
    // R6 R7: faults on each chunk of a four-chunk transfer
    for (int f = 0; f < 4; f++)
      for (int k = 0; k < 2; k++)
        for (int d = 0; d < 2; d++)
          xfer(32'h0040_0010, 'h3010, d[0], f, k, f % 2);
    summary();
    $finish;
  end
endmodule